// File: doc/BRIEF.md
# Nibble-Bus Firmware Memory Target

This block sits on the device side of a four-bit, frame-delimited firmware bus clocked in step with the 33 MHz system clock. It watches an active-low frame strobe and four communication lines. It recognises single-byte read and write cycles and accepts only those whose device-select nibble equals its four strap inputs. It then drives the sync, read-data and turnaround nibbles back to the host. The bidirectional lines are split into an input, an output and an output enable, and the pad ring joins them.

On the memory side it presents a byte-wide port with a 28-bit address, a read level, a one-clock write strobe and a stall input. The stall input lets slow storage hold a read in its sync phase for as long as it needs. Block protection lives elsewhere. This block only moves cycles between the bus and the memory port.

Top module: `fwmem_target`

## Requirements
- R1: While reset is held and in the first cycle after it, `lad_oe`, `mem_rd` and `mem_wr` are low.
- R2: A clock with `frame_n` low samples a start nibble: 4'b1101 opens a read, 4'b1110 opens a write, and any other value leaves the target silent until the next frame.
- R3: After the start clock, one device-select nibble is compared with `strap_id`. On a mismatch the target never raises `lad_oe`, `mem_rd` or `mem_wr` for that cycle.
- R4: Seven address nibbles follow, most significant first, and form the 28-bit `mem_addr`. `mem_addr` holds steady while `mem_rd` or `mem_wr` is high.
- R5: The nibble after the address is the size field. Any value other than 4'b0000 drops the cycle silently.
- R6: A read has two turnaround clocks with the lines released. Then come sync clocks driven with 4'b0101 (wait), a final sync clock driven with 4'b0000, two data clocks (low nibble first), one clock driven with 4'b1111, and release. With no stall there are exactly three sync clocks.
- R7: `mem_rd` is high during read sync until the data is taken. `mem_stall` is sampled at the end of the second sync clock and of every later sync clock. Each sample found high adds one wait clock. The byte on `mem_rdata` is captured at the first sample found low.
- R8: A write carries two host data clocks (low nibble first) and two turnaround clocks, then one sync clock. In that clock the target drives 4'b0000 and pulses `mem_wr` for exactly one clock with `mem_wdata` and `mem_addr` valid. Then comes one clock driven with 4'b1111, and release.
- R9: `frame_n` low during any phase of a cycle aborts it. The lines are released in the next clock, no pending write strobe is issued, and the same clock is decoded as a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe |
| lad_i | input | 4 | Communication lines, sampled |
| lad_o | output | 4 | Communication lines, driven value |
| lad_oe | output | 1 | Drive enable for the communication lines |
| strap_id | input | 4 | Device identity straps |
| mem_addr | output | 4*ADDR_NIB | Byte address to backing memory |
| mem_rd | output | 1 | Read request level |
| mem_wr | output | 1 | One-clock write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte from memory |
| mem_stall | input | 1 | Memory not ready, extends read sync |

## Verification
The bench builds the block with its default of seven address nibbles, so the full 28-bit address path is reachable. All-zero, all-ones and mixed-nibble addresses show the most-significant-first assembly. Stall lengths of zero to three clocks reach the wait-extension path. A changed read byte after capture shows that the target keeps the byte it latched. Strap values of 5 and A, with mismatching selects in both directions, reach the silent-target path.

// File: rtl/fwmem_target.sv
module fwmem_target #(
  parameter int ADDR_NIB = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_n,
  input  logic [3:0]            lad_i,
  output logic [3:0]            lad_o,
  output logic                  lad_oe,
  input  logic [3:0]            strap_id,
  output logic [4*ADDR_NIB-1:0] mem_addr,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic [7:0]            mem_wdata,
  input  logic [7:0]            mem_rdata,
  input  logic                  mem_stall
);
  localparam int AW = 4 * ADDR_NIB;
  localparam int CW = $clog2(ADDR_NIB + 1);
  localparam logic [3:0] START_RD = 4'b1101;
  localparam logic [3:0] START_WR = 4'b1110;
  localparam logic [3:0] SYNC_OK  = 4'b0000;
  localparam logic [3:0] SYNC_WT  = 4'b0101;

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_ADDR, S_SIZE, S_RTAR, S_RSYNC, S_RDATA,
    S_WDATA, S_WTAR, S_WSYNC, S_ETAR
  } st_t;

  st_t           st;
  logic          wr_q, rdy_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wr_q   <= 1'b0;
      rdy_q  <= 1'b0;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!frame_n) begin
      cnt   <= '0;
      rdy_q <= 1'b0;
      wr_q  <= (lad_i == START_WR);
      st    <= (lad_i == START_RD || lad_i == START_WR) ? S_ID : S_IDLE;
    end else begin
      cnt <= cnt + CW'(1);
      case (st)
        S_ID: begin
          cnt <= '0;
          st  <= (lad_i == strap_id) ? S_ADDR : S_IDLE;
        end
        S_ADDR: begin
          addr_q <= {addr_q[AW-5:0], lad_i};
          if (cnt == CW'(ADDR_NIB - 1)) st <= S_SIZE;
        end
        S_SIZE: begin
          cnt <= '0;
          if (lad_i != 4'h0) st <= S_IDLE;
          else               st <= wr_q ? S_WDATA : S_RTAR;
        end
        S_RTAR:
          if (cnt[0]) begin st <= S_RSYNC; cnt <= '0; end
        S_RSYNC: begin
          cnt <= (cnt == '0) ? CW'(1) : cnt;
          if (rdy_q) begin
            st  <= S_RDATA;
            cnt <= '0;
          end else if (cnt != '0 && !mem_stall) begin
            rdy_q  <= 1'b1;
            data_q <= mem_rdata;
          end
        end
        S_RDATA:
          if (cnt[0]) begin st <= S_ETAR; cnt <= '0; end
        S_WDATA: begin
          data_q <= {lad_i, data_q[7:4]};
          if (cnt[0]) begin st <= S_WTAR; cnt <= '0; end
        end
        S_WTAR:
          if (cnt[0]) begin st <= S_WSYNC; cnt <= '0; end
        S_WSYNC: begin
          st  <= S_ETAR;
          cnt <= '0;
        end
        S_ETAR:
          if (cnt[0]) st <= S_IDLE;
        default: cnt <= '0;
      endcase
    end
  end

  assign lad_oe = (st inside {S_RSYNC, S_RDATA, S_WSYNC}) || (st == S_ETAR && !cnt[0]);

  always_comb begin
    case (st)
      S_RSYNC: lad_o = rdy_q ? SYNC_OK : SYNC_WT;
      S_RDATA: lad_o = cnt[0] ? data_q[7:4] : data_q[3:0];
      S_ETAR:  lad_o = 4'hF;
      default: lad_o = SYNC_OK;
    endcase
  end

  assign mem_rd    = (st == S_RSYNC) && !rdy_q;
  assign mem_wr    = (st == S_WSYNC);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
endmodule

// File: rtl/fwmem_target_chk.sv
module fwmem_target_chk #(
  parameter int ADDR_NIB = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frame_n,
  input logic [3:0]            lad_o,
  input logic                  lad_oe,
  input logic [4*ADDR_NIB-1:0] mem_addr,
  input logic                  mem_rd,
  input logic                  mem_wr
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!lad_oe && !mem_rd && !mem_wr));

  p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> $stable(mem_addr));

  p_wait_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (lad_oe && lad_o == 4'b0101));

  p_rd_wr_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  p_wr_sync_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (lad_oe && lad_o == 4'b0000));

  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (!lad_oe && !mem_wr && !mem_rd));
endmodule

bind fwmem_target fwmem_target_chk #(.ADDR_NIB(ADDR_NIB)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_o(lad_o), .lad_oe(lad_oe),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/fwmem_target_tb_top.sv
module fwmem_target_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ADDR_NIB = 7;
  localparam int AW = 4 * ADDR_NIB;

  // {kind(0 rd,1 wr), id, addr, data, stall clocks}
  localparam logic [47:0] VEC [0:7] = '{
    {4'h0, 4'h5, 28'h0000000, 8'h3C, 4'h0},
    {4'h1, 4'h5, 28'hFFFFFFF, 8'hA5, 4'h0},
    {4'h0, 4'h5, 28'h1234567, 8'h96, 4'h1},
    {4'h0, 4'h5, 28'hFEDCBA9, 8'h01, 4'h3},
    {4'h1, 4'h5, 28'h89ABCDE, 8'h7E, 4'h0},
    {4'h0, 4'h4, 28'h0ABCDEF, 8'h55, 4'h0},
    {4'h1, 4'hD, 28'h1111111, 8'hFF, 4'h0},
    {4'h0, 4'h5, 28'h8000001, 8'hF0, 4'h2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_n = 1'b1;
  logic [3:0]    lad_i = 4'hF;
  logic [3:0]    lad_o;
  logic          lad_oe;
  logic [3:0]    strap_id = 4'h5;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = 8'h00;
  logic          mem_stall = 1'b0;
  int            checks = 0;
  int            errors = 0;

  always #2.5 clk = ~clk;

  fwmem_target #(.ADDR_NIB(ADDR_NIB)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_i(lad_i), .lad_o(lad_o),
    .lad_oe(lad_oe), .strap_id(strap_id), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_stall(mem_stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic f, input logic [3:0] v);
    frame_n = f;
    lad_i   = v;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      chk(req, {lad_oe, mem_rd, mem_wr}, 3'b000);
      tick(1'b1, 4'hF);
    end
  endtask

  task automatic hdr(input logic [3:0] start, input logic [3:0] id, input logic [AW-1:0] a);
    tick(1'b0, start);
    tick(1'b1, id);
    for (int i = ADDR_NIB - 1; i >= 0; i--) tick(1'b1, a[4*i +: 4]);
  endtask

  task automatic do_read(input logic [3:0] id, input logic [AW-1:0] a,
                         input logic [7:0] d, input int nstall);
    mem_rdata = d;
    mem_stall = 1'b0;
    hdr(4'b1101, id, a);
    tick(1'b1, 4'h0);
    if (id != strap_id) begin
      quiet("R3 mismatched read stays silent", 10);
      return;
    end
    chk("R6 read tar0 released", lad_oe, 1'b0);
    tick(1'b1, 4'hF);
    chk("R6 read tar1 released", lad_oe, 1'b0);
    tick(1'b1, 4'hF);
    chk("R6 sync0 wait", {lad_oe, lad_o}, {1'b1, 4'h5});
    chk("R7 mem_rd in sync", mem_rd, 1'b1);
    chk("R4 read address", mem_addr, a);
    tick(1'b1, 4'hF);
    chk("R6 sync1 wait", {lad_oe, lad_o}, {1'b1, 4'h5});
    for (int k = 0; k < nstall; k++) begin
      mem_stall = 1'b1;
      tick(1'b1, 4'hF);
      chk("R7 stall extends wait", {lad_oe, lad_o, mem_rd}, {1'b1, 4'h5, 1'b1});
    end
    mem_stall = 1'b0;
    tick(1'b1, 4'hF);
    chk("R6 ready sync", {lad_oe, lad_o}, {1'b1, 4'h0});
    chk("R7 mem_rd drops after capture", mem_rd, 1'b0);
    mem_rdata = ~d;
    tick(1'b1, 4'hF);
    chk("R6 data low nibble", {lad_oe, lad_o}, {1'b1, d[3:0]});
    tick(1'b1, 4'hF);
    chk("R6 data high nibble", {lad_oe, lad_o}, {1'b1, d[7:4]});
    tick(1'b1, 4'hF);
    chk("R6 end tar drives ones", {lad_oe, lad_o}, {1'b1, 4'hF});
    tick(1'b1, 4'hF);
    chk("R6 released after read", lad_oe, 1'b0);
  endtask

  task automatic do_write(input logic [3:0] id, input logic [AW-1:0] a, input logic [7:0] d);
    hdr(4'b1110, id, a);
    tick(1'b1, 4'h0);
    tick(1'b1, d[3:0]);
    tick(1'b1, d[7:4]);
    if (id != strap_id) begin
      quiet("R3 mismatched write stays silent", 8);
      return;
    end
    chk("R8 write tar0", {lad_oe, mem_wr}, 2'b00);
    tick(1'b1, 4'hF);
    chk("R8 write tar1", {lad_oe, mem_wr}, 2'b00);
    tick(1'b1, 4'hF);
    chk("R8 write sync", {lad_oe, lad_o, mem_wr}, {1'b1, 4'h0, 1'b1});
    chk("R8 write data", mem_wdata, d);
    chk("R4 write address", mem_addr, a);
    tick(1'b1, 4'hF);
    chk("R8 end tar ones, strobe gone", {lad_oe, lad_o, mem_wr}, {1'b1, 4'hF, 1'b0});
    tick(1'b1, 4'hF);
    chk("R8 released after write", lad_oe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", {lad_oe, mem_rd, mem_wr}, 3'b000);
    rst_n = 1'b1;
    tick(1'b1, 4'hF);
    chk("R1 first cycle after reset", {lad_oe, mem_rd, mem_wr}, 3'b000);

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][47:44] == 4'h0)
        do_read(VEC[v][43:40], VEC[v][39:12], VEC[v][11:4], int'(VEC[v][3:0]));
      else
        do_write(VEC[v][43:40], VEC[v][39:12], VEC[v][11:4]);
      tick(1'b1, 4'hF);
    end

    // R2: unknown start nibbles, followed by what would be a valid body
    tick(1'b0, 4'h0);
    tick(1'b1, 4'h5);
    quiet("R2 start 0000 ignored", 14);
    tick(1'b0, 4'hC);
    tick(1'b1, 4'h5);
    quiet("R2 start 1100 ignored", 14);

    // R5: nonzero size
    hdr(4'b1101, 4'h5, 28'h0000010);
    tick(1'b1, 4'h1);
    quiet("R5 nonzero size dropped", 10);

    // R9: abort a read in its sync phase
    hdr(4'b1101, 4'h5, 28'h0000020);
    tick(1'b1, 4'h0);
    tick(1'b1, 4'hF);
    tick(1'b1, 4'hF);
    chk("R9 read reached sync", lad_oe, 1'b1);
    tick(1'b0, 4'hF);
    quiet("R9 aborted read releases", 6);

    // R9: abort a write during data, restart decodes a new start
    hdr(4'b1110, 4'h5, 28'h0000030);
    tick(1'b1, 4'h0);
    tick(1'b1, 4'h3);
    tick(1'b0, 4'b1110);
    tick(1'b1, 4'h9);
    quiet("R9 aborted write no strobe", 10);
    do_write(4'h5, 28'h0000031, 8'hC3);
    tick(1'b1, 4'hF);

    // R3: new strap value
    strap_id = 4'hA;
    do_read(4'hA, 28'h0ABCDE0, 8'h5A, 1);
    tick(1'b1, 4'hF);
    do_read(4'h5, 28'h0000040, 8'h11, 0);
    do_write(4'h5, 28'h0000041, 8'h22);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule